// File: doc/BRIEF.md
# Flyback PWM Cycle Sequencer

This block produces the power-switch enable for a peak-current-mode flyback converter. It runs on a fast system clock, and every time value is a count of clock ticks. A period counter marks the start of each switching cycle and raises the gate there. The gate drops on one of three conditions: a trip from the voltage-loop comparator, a trip from the current-limit comparator, or the duty ceiling. The nominal cycle corresponds to 85 kHz. A slow triangle sweep dithers the period between the ticks for 88 kHz and 82 kHz to spread emissions.

To keep the converter out of continuous conduction, a cycle may only end once two things have happened: a zero-crossing of the demagnetising winding, and a hold-off of one tenth of the nominal period after it. A zero-crossing that comes early leaves the normal period boundary in charge. A zero-crossing that comes late pushes the next turn-on out. A zero-crossing that never comes is covered by the longest-period limit, which starts the next cycle anyway. Two further controls act on the gate. A burst latch driven by the feedback-low and feedback-high flags suppresses turn-on at light load. A protection input kills the gate at once.

Top module: `flyback_pwm_seq`

## Requirements
- R1: While reset is held and after it is released, `gate_o` is low. The period counter starts at zero, no zero-crossing is recorded, the burst latch is clear, and the hop period starts at PER_NOM-HOP_SPAN and sweeps upward.
- R2: A cycle start happens on the clock edge where the counter value is at least (current hop period - 1) and the zero-crossing qualifier is ready. At that edge the counter returns to 0 and `gate_o` rises, unless burst is active. With an early zero-crossing, rising edges are therefore exactly one hop period apart.
- R3: The hop period moves by exactly one tick after every HOP_DIV cycle starts. It travels as a triangle between PER_NOM-HOP_SPAN and PER_NOM+HOP_SPAN and turns around at each end.
- R4: The gate is high for at most DMAX_T = floor(PER_NOM*67/100) consecutive ticks. It falls on the edge where the counter value is DMAX_T-1.
- R5: While the gate is high, `vloop_trip_i` ends the pulse at an edge where the counter value is at least MIN_ON_T-1. The gate is therefore never cut short by this trip to fewer than MIN_ON_T ticks.
- R6: `ilim_trip_i` is ignored while the counter value is below LEB_T, so that blanking window passes without effect. After it, the trip ends the pulse, which gives a shortest current-limited pulse of LEB_T+1 ticks.
- R7: Either trip alone turns the gate off. Each trip is a level, and a trip held through its masking window takes effect at the first edge where it is honoured.
- R8: `zc_i` is recorded only while the gate is low. Each accepted pulse restarts a hold-off count, and the qualifier becomes ready HOLD_T = floor(PER_NOM*10/100) ticks after the pulse. A late zero-crossing therefore delays turn-on past the period boundary.
- R9: When the counter value reaches PER_LONG-1, a cycle starts whether or not a zero-crossing was seen.
- R10: `fb_low_i` sets the burst latch, and `fb_high_i` clears it, taking priority when both are high. While the latch is set, cycle starts still occur but the gate is not raised. A pulse already running ends by its normal rules.
- R11: `prot_off_i` forces `gate_o` low in the same cycle. At the following edge it resets the counter to 0 and clears the zero-crossing state, and no cycle starts while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all time values are ticks of it |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_off_i | input | 1 | Protection shutdown; gate off immediately, counter cleared |
| vloop_trip_i | input | 1 | Voltage-loop PWM comparator trip |
| ilim_trip_i | input | 1 | Current-limit comparator trip |
| zc_i | input | 1 | Zero-crossing detected on the auxiliary winding |
| fb_low_i | input | 1 | Feedback below the burst-stop threshold |
| fb_high_i | input | 1 | Feedback above the burst-resume threshold |
| gate_o | output | 1 | Power switch enable |

## Verification
The bench aims at pulses cut by a trip held high from turn-on. A design with an off-by-one in the blanking or minimum on-time compare would emit a pulse one tick too short or too long. It also drives zero-crossings that arrive after nine tenths of the period. If the hold-off were measured from the boundary instead of the crossing, turn-on would come early. Runs with no zero-crossing at all check that a missing longest-period escape would hang the gate low forever. Burst toggling mid-pulse and protection pulses at random points check that the latch neither truncates a running pulse nor lets the gate rise, and that shutdown acts in the same cycle.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;

    typedef enum logic {
        HOP_DOWN = 1'b0,
        HOP_UP   = 1'b1
    } hop_dir_e;

    // floor(base * pct / 100), used to derive tick windows from the period
    function automatic int pct_of(input int base, input int pct);
        return (base * pct) / 100;
    endfunction

endpackage

// File: rtl/fpwm_hop.sv
module fpwm_hop
    import fpwm_pkg::*;
#(
    parameter int PER_MIN = 114,
    parameter int PER_MAX = 122,
    parameter int HOP_DIV = 2,
    parameter int CW      = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_i,
    output logic [CW-1:0] per_o
);
    localparam int DW = (HOP_DIV > 1) ? $clog2(HOP_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(HOP_DIV - 1);
    localparam logic [CW-1:0] MIN_C    = CW'(PER_MIN);
    localparam logic [CW-1:0] MAX_C    = CW'(PER_MAX);

    typedef struct packed {
        logic [CW-1:0] per;
        hop_dir_e      dir;
        logic [DW-1:0] div;
    } hop_st_t;

    hop_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv_i) begin
            if (st_q.div == DIV_LAST) begin
                st_d.div = '0;
                if (st_q.dir == HOP_UP) begin
                    if (st_q.per == MAX_C) begin
                        st_d.dir = HOP_DOWN;
                        st_d.per = st_q.per - 1'b1;
                    end else begin
                        st_d.per = st_q.per + 1'b1;
                    end
                end else begin
                    if (st_q.per == MIN_C) begin
                        st_d.dir = HOP_UP;
                        st_d.per = st_q.per + 1'b1;
                    end else begin
                        st_d.per = st_q.per - 1'b1;
                    end
                end
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.per <= MIN_C;
            st_q.dir <= HOP_UP;
            st_q.div <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign per_o = st_q.per;

    // R3
    hop_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.per >= MIN_C) && (st_q.per <= MAX_C));

    // R3
    hop_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.per) |-> (st_q.per == $past(st_q.per) + 1'b1) ||
                               (st_q.per == $past(st_q.per) - 1'b1));

endmodule

// File: rtl/fpwm_zc.sv
module fpwm_zc #(
    parameter int HOLD_T = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic arm_i,
    output logic ready_o
);
    localparam int HW = $clog2(HOLD_T + 1);
    localparam logic [HW-1:0] HOLD_C = HW'(HOLD_T);

    typedef struct packed {
        logic          seen;
        logic [HW-1:0] ho;
    } zc_st_t;

    zc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.seen = 1'b0;
            st_d.ho   = '0;
        end else if (arm_i) begin
            st_d.seen = 1'b1;
            st_d.ho   = '0;
        end else if (st_q.seen && (st_q.ho != HOLD_C)) begin
            st_d.ho = st_q.ho + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.seen <= 1'b0;
            st_q.ho   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_o = st_q.seen && (st_q.ho == HOLD_C);

    // R8
    zc_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && !clr_i) |=> !ready_o);

endmodule

// File: rtl/fpwm_onwin.sv
module fpwm_onwin #(
    parameter int LEB_T    = 2,
    parameter int MIN_ON_T = 5,
    parameter int DMAX_T   = 79,
    parameter int CW       = 10
) (
    input  logic          on_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          vloop_i,
    input  logic          ilim_i,
    output logic          off_o
);
    localparam logic [CW-1:0] LEB_C  = CW'(LEB_T);
    localparam logic [CW-1:0] MINO_C = CW'(MIN_ON_T - 1);
    localparam logic [CW-1:0] DMAX_C = CW'(DMAX_T - 1);

    logic dmax_hit, ilim_ok, vloop_ok;

    always_comb begin
        dmax_hit = (cnt_i >= DMAX_C);
        ilim_ok  = ilim_i  && (cnt_i >= LEB_C);
        vloop_ok = vloop_i && (cnt_i >= MINO_C);
        off_o    = on_i && (dmax_hit || ilim_ok || vloop_ok);
    end

endmodule

// File: rtl/flyback_pwm_seq.sv
module flyback_pwm_seq
    import fpwm_pkg::*;
#(
    parameter int PER_NOM  = 118,
    parameter int HOP_SPAN = 4,
    parameter int HOP_DIV  = 2,
    parameter int DMAX_PCT = 67,
    parameter int HOLD_PCT = 10,
    parameter int LEB_T    = 2,
    parameter int MIN_ON_T = 5,
    parameter int PER_LONG = 556
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prot_off_i,
    input  logic vloop_trip_i,
    input  logic ilim_trip_i,
    input  logic zc_i,
    input  logic fb_low_i,
    input  logic fb_high_i,
    output logic gate_o
);
    localparam int CW     = $clog2(PER_LONG + 1);
    localparam int DMAX_T = pct_of(PER_NOM, DMAX_PCT);
    localparam int HOLD_T = pct_of(PER_NOM, HOLD_PCT);
    localparam logic [CW-1:0] LONG_C = CW'(PER_LONG - 1);
    localparam logic [CW-1:0] DMAX_C = CW'(DMAX_T);
    localparam logic [CW-1:0] LEB_C  = CW'(LEB_T);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          gate;
        logic          burst;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic [CW-1:0] per;
    logic          zc_ready, off_req, start;

    fpwm_hop #(
        .PER_MIN (PER_NOM - HOP_SPAN),
        .PER_MAX (PER_NOM + HOP_SPAN),
        .HOP_DIV (HOP_DIV),
        .CW      (CW)
    ) u_hop (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (start),
        .per_o (per)
    );

    fpwm_zc #(
        .HOLD_T (HOLD_T)
    ) u_zc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (start || prot_off_i),
        .arm_i   (zc_i && !st_q.gate),
        .ready_o (zc_ready)
    );

    fpwm_onwin #(
        .LEB_T    (LEB_T),
        .MIN_ON_T (MIN_ON_T),
        .DMAX_T   (DMAX_T),
        .CW       (CW)
    ) u_onwin (
        .on_i    (st_q.gate),
        .cnt_i   (st_q.cnt),
        .vloop_i (vloop_trip_i),
        .ilim_i  (ilim_trip_i),
        .off_o   (off_req)
    );

    always_comb begin
        start = !prot_off_i &&
                (((st_q.cnt >= per - 1'b1) && zc_ready) || (st_q.cnt >= LONG_C));

        st_d = st_q;
        if (fb_high_i)     st_d.burst = 1'b0;
        else if (fb_low_i) st_d.burst = 1'b1;

        if (prot_off_i) begin
            st_d.cnt  = '0;
            st_d.gate = 1'b0;
        end else if (start) begin
            st_d.cnt  = '0;
            st_d.gate = !st_q.burst;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.gate = st_q.gate && !off_req;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.gate  <= 1'b0;
            st_q.burst <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o = st_q.gate && !prot_off_i;

    // R4
    duty_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.gate |-> (st_q.cnt < DMAX_C));

    // R2
    rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.gate) |-> (st_q.cnt == '0));

    // R6
    blank_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.gate) && !$past(prot_off_i)) |-> ($past(st_q.cnt) >= LEB_C));

    // R9
    long_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LONG_C);

    // R11
    prot_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_off_i |=> (!st_q.gate && (st_q.cnt == '0)));

    // R11
    prot_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_off_i |-> !gate_o);

    // R10
    burst_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_q.burst) |-> !$rose(st_q.gate));

endmodule

// File: tb/flyback_pwm_seq_tb.sv
module flyback_pwm_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PER_NOM  = 118;
    localparam int HOP_SPAN = 4;
    localparam int HOP_DIV  = 2;
    localparam int LEB_T    = 2;
    localparam int MIN_ON_T = 5;
    localparam int PER_LONG = 556;
    localparam int DMAX_T   = (PER_NOM * 67) / 100;
    localparam int HOLD_T   = (PER_NOM * 10) / 100;
    localparam int PMIN     = PER_NOM - HOP_SPAN;
    localparam int PMAX     = PER_NOM + HOP_SPAN;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prot = 1'b0, vt = 1'b0, it = 1'b0, zc = 1'b0, fbl = 1'b0, fbh = 1'b0;
    logic gate;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flyback_pwm_seq u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .prot_off_i   (prot),
        .vloop_trip_i (vt),
        .ilim_trip_i  (it),
        .zc_i         (zc),
        .fb_low_i     (fbl),
        .fb_high_i    (fbh),
        .gate_o       (gate)
    );

    // reference state, built from the requirement text
    int m_cnt, m_per, m_div, m_ho;
    bit m_gate, m_burst, m_up, m_seen;
    int n_cnt;
    bit n_gate, rdy, st, offr;

    int    vectors = 0;
    int    fails   = 0;
    bit    done    = 1'b0;
    string tag     = "R1";

    function automatic bit chance(input int permille);
        return ($urandom % 1000) < permille;
    endfunction

    function automatic bit exp_gate(input bit g, input bit p);
        return g && !p;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_gate = 0; m_burst = 0;
            m_per = PMIN; m_up = 1; m_div = 0;
            m_seen = 0; m_ho = 0;
        end else begin
            rdy  = m_seen && (m_ho == HOLD_T);                       // R8
            st   = !prot && (((m_cnt >= m_per - 1) && rdy) ||
                             (m_cnt >= PER_LONG - 1));               // R2 R9
            offr = m_gate && ((m_cnt >= DMAX_T - 1) ||               // R4
                              (it && m_cnt >= LEB_T) ||              // R6
                              (vt && m_cnt >= MIN_ON_T - 1));        // R5 R7
            if (prot)    begin n_cnt = 0; n_gate = 0; end            // R11
            else if (st) begin n_cnt = 0; n_gate = !m_burst; end     // R10
            else         begin n_cnt = m_cnt + 1; n_gate = m_gate && !offr; end
            if (prot || st)           begin m_seen = 0; m_ho = 0; end
            else if (zc && !m_gate)   begin m_seen = 1; m_ho = 0; end
            else if (m_seen && m_ho < HOLD_T) m_ho = m_ho + 1;
            if (st) begin                                            // R3
                if (m_div == HOP_DIV - 1) begin
                    m_div = 0;
                    if (m_up) begin
                        if (m_per == PMAX) begin m_up = 0; m_per = m_per - 1; end
                        else m_per = m_per + 1;
                    end else begin
                        if (m_per == PMIN) begin m_up = 1; m_per = m_per + 1; end
                        else m_per = m_per - 1;
                    end
                end else m_div = m_div + 1;
            end
            if (fbh)      m_burst = 0;
            else if (fbl) m_burst = 1;
            m_cnt  = n_cnt;
            m_gate = n_gate;
        end
    end

    task automatic chk();
        bit e;
        e = exp_gate(m_gate, prot);
        vectors++;
        if (gate !== e) begin
            fails++;
            $display("FAIL %s cycle-compare gate_o: actual %0b expected %0b (cnt %0d)",
                     tag, gate, e, m_cnt);
        end
    endtask

    task automatic gen(input int mode);
        zc = 0; fbl = 0; fbh = 0; prot = 0;
        case (mode)
            1: zc = !m_gate && chance(120);
            2: begin
                zc = !m_gate && chance(120);
                if (chance(60)) vt = ~vt;
                if (chance(60)) it = ~it;
            end
            3: zc = !m_gate && (m_cnt >= 108) && chance(40);
            5: begin
                zc  = !m_gate && chance(120);
                fbl = chance(6);
                fbh = chance(6);
            end
            6: begin
                zc   = !m_gate && chance(120);
                if (chance(60)) vt = ~vt;
                if (chance(60)) it = ~it;
                fbl  = chance(6);
                fbh  = chance(6);
                prot = chance(20);
            end
            default: ;
        endcase
    endtask

    task automatic run(input int n, input int mode);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            gen(mode);
            #1;
            chk();
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: held in reset
        repeat (4) begin
            @(negedge clk);
            #1;
            chk();
        end
        @(negedge clk);
        rst_n = 1'b1;
        tag = "R1 R9"; run(700, 0);      // first turn-on only through longest period
        tag = "R2 R3 R4"; run(20000, 1);
        tag = "R5 R6 R7"; vt = 0; it = 0; run(20000, 2);
        // directed: both trips held high across turn-on (R5 R6)
        vt = 1; it = 1; tag = "R6 held trips"; run(2000, 1);
        it = 0; tag = "R5 held trip"; run(2000, 1);
        vt = 0;
        tag = "R8"; run(20000, 3);
        tag = "R9"; run(5000, 0);
        tag = "R10"; run(20000, 5);
        tag = "R11"; vt = 0; it = 0; run(20000, 6);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule